// File: doc/BRIEF.md
# Segmented Two-Way Address Translation Buffer

This block turns a 32-bit effective address into a physical address. The top four address bits pick one of sixteen segment registers, and that register supplies a 24-bit virtual segment identifier. The identifier is joined with the 16-bit page index to form a 40-bit virtual page number. That number is looked up in a cache of 128 translations, arranged as 64 sets of two ways. On a hit the block returns the physical page joined with the untouched 12-bit byte offset, together with the entry's protection, attribute, referenced and changed bits. On a miss it returns no translation. The block does not walk page tables. Software or a walker loads entries through the fill port.

Two identical banks of segment registers are kept, one for instruction fetch and one for data access. Every segment write lands in both banks in the same cycle. The parameter `SIDE` chooses which bank an instance translates with (0 for instruction, 1 for data). Each stored entry keeps its segment identifier and the page-index bits above the set index. These bits are the six-bit API field (EA[27:22]) and the four-bit extended field (EA[21:18]). Together with the set position they pin down exactly one page. Entries can be removed one set at a time, or all at once by a sweep that takes 64 cycles.

Top module: `seg_tlb2w`

## Requirements
- R1: After reset, res_hit, res_miss and busy are 0, all 128 entries are invalid, and all segment registers in both banks hold 0.
- R2: Address fields use little-endian bit numbering. Segment select is EA[31:28]. The set index is EA[17:12]. The page index is EA[27:12]. The byte offset is EA[11:0]. The virtual page number is {VSID, EA[27:12]}. A fill names its page as fill_epn = EA[31:12].
- R3: A lookup sampled at a clock edge reports its result at that edge. res_hit is 1 when a valid way of the indexed set holds the lookup's 40-bit virtual page number. res_pa is then {ppn, EA[11:0]}, and res_pp, res_attr, res_r and res_c are that entry's stored values.
- R4: A lookup with no matching way reports res_miss=1 and res_hit=0, with res_pa, res_pp, res_attr, res_r and res_c all 0. A cycle without a lookup leaves both res_hit and res_miss at 0 on the following cycle.
- R5: Two pages that differ only in EA[21:18] fall in the same set, and each one hits with its own translation.
- R6: A segment write updates the same register in the instruction bank and the data bank in one cycle. A lookup or fill sampled in the same cycle as the write still uses the old identifier.
- R7: A fill with fill_c=1 stores R as 1, whatever the value of fill_r.
- R8: A fill whose page is already valid in the set overwrites that way. Otherwise it writes way 0 if way 0 is invalid, then way 1 if way 1 is invalid, and otherwise the way named by the set's LRU bit.
- R9: Each set keeps one LRU bit, reset to 0, that names the way to replace next. A fill or a hit sets it to the other way. Invalidation leaves it unchanged.
- R10: When a fill and a lookup target the same set in the same cycle, the fill is applied and the lookup reports a miss without touching the LRU bit.
- R11: inv_en clears both ways of set inv_set. Other sets are unaffected. A fill to that same set in the same cycle ends invalid.
- R12: inv_all while idle raises busy from the next cycle for exactly 64 cycles and clears set k in the k-th of those cycles. While busy is high, lookups miss and fills, set invalidates and further inv_all requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_ea | input | 32 | Effective address to translate |
| sr_we | input | 1 | Segment register write |
| sr_idx | input | 4 | Segment register number |
| sr_vsid | input | 24 | Virtual segment identifier to write |
| fill_en | input | 1 | Load one translation |
| fill_epn | input | 20 | Effective page of the fill, EA[31:12] |
| fill_ppn | input | 20 | Physical page number |
| fill_pp | input | 2 | Page protection bits |
| fill_attr | input | 4 | Storage attribute bits |
| fill_r | input | 1 | Referenced bit |
| fill_c | input | 1 | Changed bit |
| inv_en | input | 1 | Invalidate one set |
| inv_set | input | 6 | Set index to invalidate, EA[17:12] |
| inv_all | input | 1 | Start a sweep over all sets |
| res_hit | output | 1 | Lookup hit, one cycle after the request |
| res_miss | output | 1 | Lookup miss, one cycle after the request |
| res_pa | output | 32 | Physical address on a hit |
| res_pp | output | 2 | Protection bits on a hit |
| res_attr | output | 4 | Attribute bits on a hit |
| res_r | output | 1 | Referenced bit on a hit |
| res_c | output | 1 | Changed bit on a hit |
| busy | output | 1 | Sweep in progress |

## Verification
The tests start with directed sequences aimed at single behaviours. Pages are chosen to share a set index and a page index but differ in segment. This separates the segment-identifier part of the tag from the page-index part. Pages that differ only in EA[21:18] or only in EA[27:22] fill one set, and the order in which later fills evict them shows whether the fill placement and the LRU bit behave as specified. Segment writes, fills and invalidates are placed in the same cycle as a lookup of the same set to pin down which side wins. After the directed part, a long random run mixes traffic over a small pool of segments and sets so that hits, evictions and sweeps happen often. Every cycle of it is compared with a behavioural model.

// File: rtl/seg_tlb_pkg.sv
`timescale 1ns/1ps
package seg_tlb_pkg;
  localparam int EA_W   = 32;
  localparam int SEG_W  = 4;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int SET_W  = 6;
  localparam int OFS_W  = 12;
  localparam int PPN_W  = 20;
  localparam int PP_W   = 2;
  localparam int ATTR_W = 4;
  localparam int NSEG   = 1 << SEG_W;
  localparam int NSETS  = 1 << SET_W;
  localparam int NWAYS  = 2;
  localparam int TAG_W  = VSID_W + PIDX_W - SET_W;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [PP_W-1:0]   pp;
    logic [ATTR_W-1:0] attr;
    logic              r;
    logic              c;
  } tlb_data_t;

  localparam int DATA_W = $bits(tlb_data_t);

  function automatic logic [SEG_W-1:0] ea_seg(logic [EA_W-1:0] ea);
    return ea[EA_W-1 -: SEG_W];
  endfunction

  function automatic logic [SET_W-1:0] ea_set(logic [EA_W-1:0] ea);
    return ea[OFS_W +: SET_W];
  endfunction

  // stored tag = identifier plus the page-index bits above the set index
  function automatic logic [TAG_W-1:0] make_tag(logic [VSID_W-1:0] vsid, logic [EA_W-1:0] ea);
    return {vsid, ea[OFS_W+SET_W +: PIDX_W-SET_W]};
  endfunction

  // matching way first, then first invalid way, then the LRU way
  function automatic logic pick_way(logic [NWAYS-1:0] vld, logic [NWAYS-1:0] match, logic lru);
    if (match[0])     return 1'b0;
    if (match[1])     return 1'b1;
    if (!vld[0])      return 1'b0;
    if (!vld[1])      return 1'b1;
    return lru;
  endfunction
endpackage

// File: rtl/tlb_seg_bank.sv
`timescale 1ns/1ps
module tlb_seg_bank
  import seg_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [VSID_W-1:0] wr_vsid,
  input  logic [SEG_W-1:0]  rd_a_idx,
  input  logic [SEG_W-1:0]  rd_b_idx,
  output logic [VSID_W-1:0] rd_a,
  output logic [VSID_W-1:0] rd_b
);
  logic [VSID_W-1:0] sr_q [NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) sr_q[i] <= '0;
    end else if (we) begin
      sr_q[wr_idx] <= wr_vsid;
    end
  end

  assign rd_a = sr_q[rd_a_idx];
  assign rd_b = sr_q[rd_b_idx];
endmodule

// File: rtl/tlb_way_store.sv
`timescale 1ns/1ps
module tlb_way_store #(
  parameter int SW = 6,
  parameter int TW = 34,
  parameter int DW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_set,
  output logic          rd_valid,
  output logic [TW-1:0] rd_tag,
  output logic [DW-1:0] rd_data,
  input  logic [SW-1:0] fs_set,
  output logic          fs_valid,
  output logic [TW-1:0] fs_tag,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_set
);
  localparam int SETS = 1 << SW;

  logic [SETS-1:0] vld_q;
  logic [TW-1:0]   tag_q [SETS];
  logic [DW-1:0]   dat_q [SETS];

  // a clear in the same cycle as a write to that set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_set]  <= 1'b1;
      if (clr_en) vld_q[clr_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set] <= wr_tag;
      dat_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = dat_q[rd_set];
  assign fs_valid = vld_q[fs_set];
  assign fs_tag   = tag_q[fs_set];
endmodule

// File: rtl/seg_tlb2w.sv
`timescale 1ns/1ps
module seg_tlb2w
  import seg_tlb_pkg::*;
#(
  parameter bit SIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [EA_W-1:0]   lkp_ea,
  input  logic              sr_we,
  input  logic [SEG_W-1:0]  sr_idx,
  input  logic [VSID_W-1:0] sr_vsid,
  input  logic              fill_en,
  input  logic [EA_W-OFS_W-1:0] fill_epn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PP_W-1:0]   fill_pp,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              fill_r,
  input  logic              fill_c,
  input  logic              inv_en,
  input  logic [SET_W-1:0]  inv_set,
  input  logic              inv_all,
  output logic              res_hit,
  output logic              res_miss,
  output logic [EA_W-1:0]   res_pa,
  output logic [PP_W-1:0]   res_pp,
  output logic [ATTR_W-1:0] res_attr,
  output logic              res_r,
  output logic              res_c,
  output logic              busy
);
  logic [EA_W-1:0]   fill_ea;
  logic [SET_W-1:0]  lkp_set, fill_set, clr_set, flush_cnt;
  logic [VSID_W-1:0] vsid_lkp  [NWAYS];
  logic [VSID_W-1:0] vsid_fill [NWAYS];
  logic [VSID_W-1:0] lkp_vsid, fill_vsid;
  logic [TAG_W-1:0]  lkp_tag, fill_tag;
  logic [TAG_W-1:0]  rd_tag [NWAYS];
  logic [TAG_W-1:0]  fs_tag [NWAYS];
  logic [DATA_W-1:0] rd_data [NWAYS];
  logic [NWAYS-1:0]  rd_valid, fs_valid, way_hit, fill_match, way_we;
  logic [NSETS-1:0]  lru_q;
  logic              busy_q, fill_go, inv_go, flush_go, collide, lkp_ok;
  logic              any_hit, hit_way, fill_way, clr_en;
  tlb_data_t         hit_data, fill_data;

  assign fill_ea  = {fill_epn, {OFS_W{1'b0}}};
  assign lkp_set  = ea_set(lkp_ea);
  assign fill_set = ea_set(fill_ea);

  // two shadow banks, both written by every segment write
  for (genvar b = 0; b < NWAYS; b++) begin : g_bank
    tlb_seg_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sr_we),
      .wr_idx  (sr_idx),
      .wr_vsid (sr_vsid),
      .rd_a_idx(ea_seg(lkp_ea)),
      .rd_b_idx(ea_seg(fill_ea)),
      .rd_a    (vsid_lkp[b]),
      .rd_b    (vsid_fill[b])
    );
  end

  assign lkp_vsid  = SIDE ? vsid_lkp[1]  : vsid_lkp[0];
  assign fill_vsid = SIDE ? vsid_fill[1] : vsid_fill[0];
  assign lkp_tag   = make_tag(lkp_vsid, lkp_ea);
  assign fill_tag  = make_tag(fill_vsid, fill_ea);

  // control events
  assign fill_go  = fill_en && !busy_q;
  assign inv_go   = inv_en && !busy_q;
  assign flush_go = inv_all && !busy_q;
  assign collide  = fill_go && (fill_set == lkp_set);
  assign lkp_ok   = lkp_valid && !busy_q && !collide;
  assign clr_en   = inv_go || busy_q;
  assign clr_set  = busy_q ? flush_cnt : inv_set;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    tlb_way_store #(.SW(SET_W), .TW(TAG_W), .DW(DATA_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (lkp_set),
      .rd_valid(rd_valid[w]),
      .rd_tag  (rd_tag[w]),
      .rd_data (rd_data[w]),
      .fs_set  (fill_set),
      .fs_valid(fs_valid[w]),
      .fs_tag  (fs_tag[w]),
      .wr_en   (way_we[w]),
      .wr_set  (fill_set),
      .wr_tag  (fill_tag),
      .wr_data (fill_data),
      .clr_en  (clr_en),
      .clr_set (clr_set)
    );
    assign way_hit[w]    = rd_valid[w] && (rd_tag[w] == lkp_tag);
    assign fill_match[w] = fs_valid[w] && (fs_tag[w] == fill_tag);
    assign way_we[w]     = fill_go && (fill_way == w[0]);
  end

  assign any_hit  = lkp_ok && (|way_hit);
  assign hit_way  = way_hit[1];
  assign hit_data = tlb_data_t'(hit_way ? rd_data[1] : rd_data[0]);
  assign fill_way = pick_way(fs_valid, fill_match, lru_q[fill_set]);

  always_comb begin
    fill_data      = '0;
    fill_data.ppn  = fill_ppn;
    fill_data.pp   = fill_pp;
    fill_data.attr = fill_attr;
    fill_data.c    = fill_c;
    fill_data.r    = fill_r || fill_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      if (fill_go) lru_q[fill_set] <= ~fill_way;
      if (any_hit) lru_q[lkp_set]  <= ~hit_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      flush_cnt <= '0;
    end else if (flush_go) begin
      busy_q    <= 1'b1;
      flush_cnt <= '0;
    end else if (busy_q) begin
      flush_cnt <= flush_cnt + 1'b1;
      if (&flush_cnt) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hit  <= 1'b0;
      res_miss <= 1'b0;
      res_pa   <= '0;
      res_pp   <= '0;
      res_attr <= '0;
      res_r    <= 1'b0;
      res_c    <= 1'b0;
    end else begin
      res_hit  <= any_hit;
      res_miss <= lkp_valid && !any_hit;
      res_pa   <= any_hit ? {hit_data.ppn, lkp_ea[OFS_W-1:0]} : '0;
      res_pp   <= any_hit ? hit_data.pp   : '0;
      res_attr <= any_hit ? hit_data.attr : '0;
      res_r    <= any_hit && hit_data.r;
      res_c    <= any_hit && hit_data.c;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/seg_tlb2w_chk.sv
`timescale 1ns/1ps
module seg_tlb2w_chk
  import seg_tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_valid,
  input logic [SET_W-1:0]  lkp_set,
  input logic              fill_en,
  input logic [SET_W-1:0]  fill_set,
  input logic              busy,
  input logic              res_hit,
  input logic              res_miss,
  input logic [EA_W-1:0]   res_pa,
  input logic              res_r,
  input logic              res_c,
  input logic [NWAYS-1:0]  way_hit,
  input logic [VSID_W-1:0] vsid_i,
  input logic [VSID_W-1:0] vsid_d
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(res_hit && res_miss)); // R4
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) lkp_valid |=> (res_hit || res_miss)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lkp_valid |=> (!res_hit && !res_miss)); // R4
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) res_miss |-> (res_pa == '0)); // R4
  AST_C_IMPLIES_R: assert property (@(posedge clk) disable iff (!rst_n) res_c |-> res_r); // R7
  AST_BANKS_AGREE: assert property (@(posedge clk) disable iff (!rst_n) vsid_i == vsid_d); // R6
  AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n) $countones(way_hit) <= 1); // R8
  AST_SWEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (busy && lkp_valid) |=> res_miss); // R12
  AST_FILL_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && fill_en && !busy && (lkp_set == fill_set)) |=> res_miss); // R10
endmodule

bind seg_tlb2w seg_tlb2w_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lkp_valid(lkp_valid),
  .lkp_set  (lkp_set),
  .fill_en  (fill_en),
  .fill_set (fill_set),
  .busy     (busy),
  .res_hit  (res_hit),
  .res_miss (res_miss),
  .res_pa   (res_pa),
  .res_r    (res_r),
  .res_c    (res_c),
  .way_hit  (way_hit),
  .vsid_i   (vsid_lkp[0]),
  .vsid_d   (vsid_lkp[1])
);

// File: tb/seg_tlb2w_tb.sv
`timescale 1ns/1ps
module seg_tlb2w_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_ea = '0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [23:0] sr_vsid = '0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_epn = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_pp = '0;
  logic [3:0]  fill_attr = '0;
  logic        fill_r = 1'b0;
  logic        fill_c = 1'b0;
  logic        inv_en = 1'b0;
  logic [5:0]  inv_set = '0;
  logic        inv_all = 1'b0;
  logic        res_hit, res_miss, res_r, res_c, busy;
  logic [31:0] res_pa;
  logic [1:0]  res_pp;
  logic [3:0]  res_attr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  seg_tlb2w #(.SIDE(1'b1)) u_dut (.*);

  // behavioural reference model
  bit          m_v   [128];
  logic [39:0] m_vpn [128];
  logic [19:0] m_ppn [128];
  logic [1:0]  m_pp  [128];
  logic [3:0]  m_at  [128];
  bit          m_r   [128];
  bit          m_c   [128];
  bit          m_lru [64];
  logic [23:0] m_sr  [16];
  bit          m_busy;
  int          m_cnt;
  logic [31:0] e_pa;
  logic [1:0]  e_pp;
  logic [3:0]  e_at;
  bit          e_hit, e_miss, e_r, e_c, e_busy;

  always @(posedge clk) begin
    int s, fs, hw, vic;
    logic [39:0] tg;
    logic [31:0] fea;
    cmp_on = 1;
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      foreach (m_lru[i]) m_lru[i] = 0;
      foreach (m_sr[i]) m_sr[i] = '0;
      m_busy = 0; m_cnt = 0;
      e_hit = 0; e_miss = 0; e_pa = '0; e_pp = '0; e_at = '0; e_r = 0; e_c = 0; e_busy = 0;
    end else begin
      e_hit = 0; e_miss = 0; e_pa = '0; e_pp = '0; e_at = '0; e_r = 0; e_c = 0;
      hw = -1; s = 0;
      if (lkp_valid) begin
        s  = int'(lkp_ea[17:12]);
        tg = {m_sr[lkp_ea[31:28]], lkp_ea[27:12]};
        if (!m_busy && !(fill_en && fill_epn[5:0] == lkp_ea[17:12]))
          for (int w = 0; w < 2; w++) if (m_v[s*2+w] && m_vpn[s*2+w] == tg) hw = w;
        if (hw >= 0) begin
          e_hit = 1;
          e_pa = {m_ppn[s*2+hw], lkp_ea[11:0]};
          e_pp = m_pp[s*2+hw]; e_at = m_at[s*2+hw];
          e_r = m_r[s*2+hw]; e_c = m_c[s*2+hw];
        end else e_miss = 1;
      end
      if (fill_en && !m_busy) begin
        fea = {fill_epn, 12'h000};
        fs  = int'(fea[17:12]);
        tg  = {m_sr[fea[31:28]], fea[27:12]};
        vic = -1;
        for (int w = 0; w < 2; w++) if (vic < 0 && m_v[fs*2+w] && m_vpn[fs*2+w] == tg) vic = w;
        for (int w = 0; w < 2; w++) if (vic < 0 && !m_v[fs*2+w]) vic = w;
        if (vic < 0) vic = m_lru[fs] ? 1 : 0;
        m_v[fs*2+vic] = 1; m_vpn[fs*2+vic] = tg; m_ppn[fs*2+vic] = fill_ppn;
        m_pp[fs*2+vic] = fill_pp; m_at[fs*2+vic] = fill_attr;
        m_r[fs*2+vic] = fill_r | fill_c; m_c[fs*2+vic] = fill_c;
        m_lru[fs] = (vic == 0);
      end
      if (hw >= 0) m_lru[s] = (hw == 0);
      if (inv_en && !m_busy) begin
        m_v[int'(inv_set)*2] = 0; m_v[int'(inv_set)*2+1] = 0;
      end
      if (m_busy) begin
        m_v[m_cnt*2] = 0; m_v[m_cnt*2+1] = 0;
        m_cnt++;
        if (m_cnt == 64) m_busy = 0;
      end else if (inv_all) begin
        m_busy = 1; m_cnt = 0;
      end
      if (sr_we) m_sr[sr_idx] = sr_vsid;
      e_busy = m_busy;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      total++;
      if ({res_hit, res_miss, res_pa, res_pp, res_attr, res_r, res_c, busy} !==
          {e_hit, e_miss, e_pa, e_pp, e_at, e_r, e_c, e_busy}) begin
        bad++;
        $display("FAIL %s model: act hit=%0b miss=%0b pa=%h pp=%0d at=%h r=%0b c=%0b busy=%0b exp hit=%0b miss=%0b pa=%h pp=%0d at=%h r=%0b c=%0b busy=%0b",
                 cur_req, res_hit, res_miss, res_pa, res_pp, res_attr, res_r, res_c, busy,
                 e_hit, e_miss, e_pa, e_pp, e_at, e_r, e_c, e_busy);
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_sr(logic [3:0] idx, logic [23:0] v);
    sr_we = 1; sr_idx = idx; sr_vsid = v;
    step();
    sr_we = 0;
  endtask

  task automatic do_fill(logic [31:0] ea, logic [19:0] ppn, logic r, logic c);
    fill_en = 1; fill_epn = ea[31:12]; fill_ppn = ppn;
    fill_pp = ppn[1:0]; fill_attr = ppn[7:4]; fill_r = r; fill_c = c;
    step();
    fill_en = 0;
  endtask

  task automatic look(logic [31:0] ea, bit exp_hit, logic [19:0] exp_ppn, string req);
    lkp_valid = 1; lkp_ea = ea;
    step();
    lkp_valid = 0;
    chk(res_hit === exp_hit && res_miss === !exp_hit, req, {62'd0, res_hit, res_miss}, {62'd0, exp_hit, !exp_hit});
    if (exp_hit) chk(res_pa === {exp_ppn, ea[11:0]}, req, 64'(res_pa), 64'({exp_ppn, ea[11:0]}));
    else         chk(res_pa === '0, req, 64'(res_pa), 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1;
    step();
    cur_req = "R1";
    chk(!res_hit && !res_miss && !busy, "R1", {61'd0, res_hit, res_miss, busy}, 64'd0);
    look(32'h1234_5678, 0, '0, "R1");

    cur_req = "R6";
    do_sr(4'd1, 24'hABCDE1);
    do_sr(4'd2, 24'h000222);

    cur_req = "R3";
    do_fill(32'h1040_3000, 20'h11111, 0, 0);
    look(32'h1040_3045, 1, 20'h11111, "R3");
    chk(res_pp === 2'd1 && res_attr === 4'h1, "R3", {58'd0, res_pp, res_attr}, {58'd0, 2'd1, 4'h1});

    cur_req = "R2";
    look(32'h2040_3000, 0, '0, "R2");
    do_sr(4'd2, 24'hABCDE1);
    look(32'h2040_3ABC, 1, 20'h11111, "R2");

    cur_req = "R6";
    sr_we = 1; sr_idx = 4'd1; sr_vsid = 24'h777777;
    look(32'h1040_3000, 1, 20'h11111, "R6");
    sr_we = 0;
    look(32'h1040_3000, 0, '0, "R6");
    do_sr(4'd1, 24'hABCDE1);

    cur_req = "R5";
    do_fill(32'h1044_3000, 20'h22222, 0, 0);
    look(32'h1040_3001, 1, 20'h11111, "R5");
    look(32'h1044_3002, 1, 20'h22222, "R5");

    cur_req = "R9";
    do_fill(32'h1080_3000, 20'h30303, 0, 0);
    look(32'h1040_3000, 0, '0, "R9");
    look(32'h1044_3000, 1, 20'h22222, "R9");
    look(32'h1080_3000, 1, 20'h30303, "R9");
    do_fill(32'h10C0_3000, 20'h44444, 0, 0);
    look(32'h1044_3000, 0, '0, "R8");
    look(32'h1080_3000, 1, 20'h30303, "R9");
    look(32'h10C0_3000, 1, 20'h44444, "R9");

    cur_req = "R8";
    do_fill(32'h1080_3000, 20'h33333, 0, 0);
    look(32'h10C0_3000, 1, 20'h44444, "R8");
    look(32'h1080_3000, 1, 20'h33333, "R8");

    cur_req = "R7";
    do_fill(32'h1000_5000, 20'h55555, 0, 1);
    look(32'h1000_5010, 1, 20'h55555, "R7");
    chk(res_r === 1'b1 && res_c === 1'b1, "R7", {62'd0, res_r, res_c}, 64'd3);

    cur_req = "R10";
    fill_en = 1; fill_epn = 20'h11003; fill_ppn = 20'h66666;
    look(32'h1080_3000, 0, '0, "R10");
    fill_en = 0;
    look(32'h1080_3000, 1, 20'h33333, "R10");

    cur_req = "R11";
    inv_en = 1; inv_set = 6'h03;
    step();
    inv_en = 0;
    look(32'h1080_3000, 0, '0, "R11");
    look(32'h1000_5000, 1, 20'h55555, "R11");
    fill_en = 1; fill_epn = 20'h10007; fill_ppn = 20'h77777;
    inv_en = 1; inv_set = 6'h07;
    step();
    fill_en = 0; inv_en = 0;
    look(32'h1000_7000, 0, '0, "R11");

    cur_req = "R12";
    do_fill(32'h1000_9000, 20'h99999, 0, 0);
    look(32'h1000_9000, 1, 20'h99999, "R12");
    inv_all = 1;
    step();
    inv_all = 0;
    chk(busy === 1'b1, "R12", 64'(busy), 64'd1);
    look(32'h1000_9000, 0, '0, "R12");
    do_fill(32'h1000_A000, 20'hAAAAA, 0, 0);
    inv_all = 1; step(); inv_all = 0;
    repeat (70) step();
    chk(busy === 1'b0, "R12", 64'(busy), 64'd0);
    look(32'h1000_9000, 0, '0, "R12");
    look(32'h1000_A000, 0, '0, "R12");
    look(32'h1000_5000, 0, '0, "R12");
    inv_all = 1; step(); inv_all = 0;
    n = 0;
    for (int i = 0; i < 80; i++) begin
      if (busy) n++;
      step();
    end
    chk(n == 64, "R12", 64'(n), 64'd64);
    do_fill(32'h1000_A000, 20'hAAAAA, 0, 0);
    look(32'h1000_A000, 1, 20'hAAAAA, "R12");

    cur_req = "R4";
    step();
    chk(!res_hit && !res_miss, "R4", {62'd0, res_hit, res_miss}, 64'd0);

    // random mix over a small address pool, compared with the model each cycle
    cur_req = "R3";
    do_sr(4'd3, 24'h0F0F0F);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ea;
      ea = {($urandom_range(0, 1) ? 4'd1 : 4'd3), 4'h0, 2'($urandom_range(0, 3)),
            2'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(3, 4)), 12'($urandom)};
      lkp_valid = ($urandom_range(0, 1) == 1);
      lkp_ea = ea;
      fill_en = ($urandom_range(0, 3) == 0);
      fill_epn = {ea[31:18], 4'h0, 1'b0, ($urandom_range(0, 1) == 1)} | 20'h00003;
      fill_ppn = 20'($urandom); fill_pp = 2'($urandom); fill_attr = 4'($urandom);
      fill_r = ($urandom_range(0, 1) == 1); fill_c = ($urandom_range(0, 1) == 1);
      inv_en = ($urandom_range(0, 40) == 0); inv_set = 6'($urandom_range(3, 4));
      sr_we = ($urandom_range(0, 60) == 0); sr_idx = ($urandom_range(0, 1) ? 4'd1 : 4'd3);
      sr_vsid = ($urandom_range(0, 1) ? 24'hABCDE1 : 24'h0F0F0F);
      inv_all = ($urandom_range(0, 1500) == 0);
      step();
    end
    lkp_valid = 0; fill_en = 0; inv_en = 0; sr_we = 0; inv_all = 0;
    repeat (70) step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule